// File: doc/BRIEF.md
# Variable-Page-Size Associative Translation Buffer

This block is a small, fully associative address translation cache for a processor memory unit. Every entry covers a pair of adjacent virtual pages, an even one and an odd one, and maps each of them to its own physical frame. Each entry keeps its own page-size mask. The mask widens the part of the address that passes through untranslated and narrows the part that is compared. An entry can also be marked global, which makes it match under any address-space identifier.

Software, or a refill engine, fills an entry at a chosen index from four register images: a high word with the virtual page and the address-space identifier, a page-size mask, and one low word for each half. A combinational translate port takes an address, a read/write flag and the current identifier. It returns a physical address together with one of four outcomes: success, miss, invalid fault or modified fault. A combinational probe port takes a high-word image and reports the lowest index that matches it.

Top module: `vpt_tlb`

## Requirements
- R1: A fill stores the entry at `wr_idx` and takes effect at the next rising clock edge. The entry takes its virtual page from `wr_hi` with bits 12:0 cleared and its identifier from `wr_hi[7:0]`. It is global only when bit 0 of both low words is set. Translate and probe results do not change in the cycle the fill is presented.
- R2: Of the mask written, only bits 28:13 are kept. The effective mask is those bits OR 0x1FFF.
- R3: An entry matches when it is global or its identifier equals the presented one, and when the address and the stored page are equal once the effective-mask bits are cleared from both.
- R4: The odd half is selected when the address bit at the highest set bit of the effective mask is one. Otherwise the even half is selected.
- R5: If the selected half's valid flag (low word bit 1) is clear, the outcome is invalid fault.
- R6: A read of a valid half succeeds. A write succeeds only when the dirty flag (low word bit 2) is set, and gives a modified fault otherwise.
- R7: On success, `tr_pa` is the frame base (low word bits 31:12, followed by twelve zero bits) OR the address bits under the effective mask shifted right by one. On any other outcome `tr_pa` is zero.
- R8: `tr_status` is coded 0 for success, 1 for miss, 2 for invalid and 3 for modified. Miss is reported when no entry matches. When several entries match, the lowest index is used.
- R9: The probe returns the lowest matching index, zero-extended, in `pr_index`. The probe takes its identifier from `pr_hi[7:0]`. When nothing matches it returns 0x8000_0000.
- R10: A synchronous active-low reset clears every valid flag and sets every entry to page 0, identifier 0, non-global, with the minimum mask. No translation can succeed in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Fill strobe |
| wr_idx | input | IDX_W | Entry index to fill |
| wr_hi | input | 32 | Virtual page and identifier image |
| wr_mask | input | 32 | Page-size mask image |
| wr_lo0 | input | 32 | Even-half frame base and flags |
| wr_lo1 | input | 32 | Odd-half frame base and flags |
| tr_va | input | 32 | Address to translate |
| tr_write | input | 1 | Access is a write |
| tr_asid | input | 8 | Current address-space identifier |
| tr_pa | output | 32 | Translated physical address |
| tr_status | output | 2 | Translation outcome |
| pr_hi | input | 32 | Probe page and identifier image |
| pr_index | output | 32 | Probe result index or failure word |

## Verification
A fill and a translation of the same address can fall in the same cycle. The translate port must still answer from the old contents and change only after the edge. The bench provokes this by presenting a fill that overwrites an entry while it translates the address the new contents would map. It expects a miss in that cycle and the new physical address in the following cycle, with both inputs held. The checker adds two more rules: outputs that do not change without a fill, and agreement between probe and translate for the same page.

// File: rtl/vpt_pkg.sv
// Shared constants and types for the variable-page-size translation buffer.
// Assumes 32-bit addresses, 4 KB minimum pages and 8-bit identifiers.
package vpt_pkg;
    localparam int VA_W      = 32;
    localparam int ASID_W    = 8;
    localparam int PAGE_BITS = 12;
    localparam int PAIR_BITS = PAGE_BITS + 1;
    localparam int MASK_TOP  = 28;

    localparam logic [VA_W-1:0] PAIR_LOW  = (VA_W'(1) << PAIR_BITS) - VA_W'(1);
    localparam logic [VA_W-1:0] MASK_KEEP = ((VA_W'(1) << (MASK_TOP + 1)) - VA_W'(1)) & ~PAIR_LOW;

    typedef enum logic [1:0] {
        TR_OK       = 2'd0,
        TR_MISS     = 2'd1,
        TR_INVALID  = 2'd2,
        TR_MODIFIED = 2'd3
    } tr_stat_e;

    typedef struct packed {
        logic [VA_W-1:0]   vpn;
        logic [VA_W-1:0]   emask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [VA_W-1:0]   base0;
        logic [VA_W-1:0]   base1;
        logic              v0;
        logic              v1;
        logic              d0;
        logic              d1;
    } tlb_ent_t;

    localparam tlb_ent_t ENT_RESET = '{
        vpn: '0, emask: PAIR_LOW, asid: '0, glob: 1'b0,
        base0: '0, base1: '0, v0: 1'b0, v1: 1'b0, d0: 1'b0, d1: 1'b0
    };
endpackage

// File: rtl/vpt_store.sv
// Entry storage: decodes the four register images into an entry and writes
// it at the chosen index on the clock edge. Assumes wr_idx < N.
module vpt_store
    import vpt_pkg::*;
#(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [VA_W-1:0]      wr_hi,
    input  logic [VA_W-1:0]      wr_mask,
    input  logic [VA_W-1:0]      wr_lo0,
    input  logic [VA_W-1:0]      wr_lo1,
    output tlb_ent_t [N-1:0]     ents_o
);
    tlb_ent_t fill_ent;
    tlb_ent_t ents_q [N];

    // Build the entry image from the register words.
    always_comb begin
        fill_ent.vpn   = wr_hi & ~PAIR_LOW;
        fill_ent.emask = (wr_mask & MASK_KEEP) | PAIR_LOW;
        fill_ent.asid  = wr_hi[ASID_W-1:0];
        fill_ent.glob  = wr_lo0[0] & wr_lo1[0];
        fill_ent.base0 = {wr_lo0[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        fill_ent.base1 = {wr_lo1[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        fill_ent.v0    = wr_lo0[1];
        fill_ent.v1    = wr_lo1[1];
        fill_ent.d0    = wr_lo0[2];
        fill_ent.d1    = wr_lo1[2];
    end

    for (genvar g = 0; g < N; g++) begin : g_ent
        // Hold one entry; reset wins over a fill.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ents_q[g] <= ENT_RESET;
            else if (wr_en && wr_idx == IW'(g))
                ents_q[g] <= fill_ent;
        end
        assign ents_o[g] = ents_q[g];
    end
endmodule

// File: rtl/vpt_match.sv
// Per-entry match vector: global-or-identifier check and masked page compare.
// Purely combinational; one comparator per entry.
module vpt_match
    import vpt_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_ent_t [N-1:0]  ents,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    output logic [N-1:0]      hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic id_ok;
        logic pg_ok;
        // Compare one entry under its own effective mask.
        always_comb begin
            id_ok  = ents[g].glob || (ents[g].asid == asid);
            pg_ok  = (va & ~ents[g].emask) == (ents[g].vpn & ~ents[g].emask);
            hit[g] = id_ok && pg_ok;
        end
    end
endmodule

// File: rtl/vpt_first.sv
// Lowest-index selector over a request vector. Reports whether any bit is set.
module vpt_first #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vpt_tlb.sv
// Variable-page-size fully associative translation buffer (top level).
// Holds N_ENTRIES even/odd page-pair entries, each with its own mask. Fills
// are registered; translate and probe are combinational. Assumes frame bases
// are aligned to the page size the mask selects.
module vpt_tlb
    import vpt_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_hi,
    input  logic [31:0]       wr_mask,
    input  logic [31:0]       wr_lo0,
    input  logic [31:0]       wr_lo1,
    input  logic [31:0]       tr_va,
    input  logic              tr_write,
    input  logic [7:0]        tr_asid,
    output logic [31:0]       tr_pa,
    output logic [1:0]        tr_status,
    input  logic [31:0]       pr_hi,
    output logic [31:0]       pr_index
);
    tlb_ent_t [N_ENTRIES-1:0] ents;
    logic [N_ENTRIES-1:0]     tr_hit, pr_hit;
    logic                     tr_found, pr_found;
    logic [IDX_W-1:0]         tr_idx, pr_idx;

    vpt_store #(.N(N_ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_hi(wr_hi), .wr_mask(wr_mask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .ents_o(ents)
    );

    vpt_match #(.N(N_ENTRIES)) u_tr_match (
        .ents(ents), .va(tr_va), .asid(tr_asid), .hit(tr_hit)
    );
    vpt_first #(.N(N_ENTRIES)) u_tr_first (
        .req(tr_hit), .found(tr_found), .idx(tr_idx)
    );

    vpt_match #(.N(N_ENTRIES)) u_pr_match (
        .ents(ents), .va(pr_hi), .asid(pr_hi[ASID_W-1:0]), .hit(pr_hit)
    );
    vpt_first #(.N(N_ENTRIES)) u_pr_first (
        .req(pr_hit), .found(pr_found), .idx(pr_idx)
    );

    tlb_ent_t        sel;
    logic [31:0]     odd_bit, off_mask, base;
    logic            is_odd, half_v, half_d;
    tr_stat_e        stat;

    // Pick the half, check its flags and form the physical address.
    always_comb begin
        sel      = ents[tr_idx];
        odd_bit  = sel.emask & ~(sel.emask >> 1);
        off_mask = sel.emask >> 1;
        is_odd   = |(tr_va & odd_bit);
        half_v   = is_odd ? sel.v1 : sel.v0;
        half_d   = is_odd ? sel.d1 : sel.d0;
        base     = is_odd ? sel.base1 : sel.base0;
        if (!tr_found)
            stat = TR_MISS;
        else if (!half_v)
            stat = TR_INVALID;
        else if (tr_write && !half_d)
            stat = TR_MODIFIED;
        else
            stat = TR_OK;
        tr_status = stat;
        tr_pa     = (stat == TR_OK) ? (base | (tr_va & off_mask)) : 32'd0;
    end

    // Probe result word: index or failure flag.
    always_comb begin
        pr_index = pr_found ? 32'(pr_idx) : 32'h8000_0000;
    end
endmodule

// File: rtl/vpt_tlb_chk.sv
// Port-level property checker for vpt_tlb, attached by bind.
module vpt_tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] tr_va,
    input logic        tr_write,
    input logic [7:0]  tr_asid,
    input logic [31:0] tr_pa,
    input logic [1:0]  tr_status,
    input logic [31:0] pr_hi,
    input logic [31:0] pr_index
);
    AST_NO_HIT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> tr_status != 2'd0); // R10

    AST_MODIFIED_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tr_status == 2'd3 |-> tr_write); // R6

    AST_PROBE_FAIL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        pr_index[31] |-> pr_index[30:0] == 31'd0); // R9

    AST_PROBE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_hi[31:13] == tr_va[31:13] && pr_hi[7:0] == tr_asid)
        |-> ((tr_status == 2'd1) == pr_index[31])); // R3

    AST_HOLD_WITHOUT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $stable(tr_va) && $stable(tr_write)
         && $stable(tr_asid)) |-> ($stable(tr_status) && $stable(tr_pa))); // R1

    AST_PA_ZERO_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        tr_status != 2'd0 |-> tr_pa == 32'd0); // R7
endmodule

bind vpt_tlb vpt_tlb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tr_va(tr_va),
    .tr_write(tr_write), .tr_asid(tr_asid), .tr_pa(tr_pa),
    .tr_status(tr_status), .pr_hi(pr_hi), .pr_index(pr_index)
);

// File: tb/sim_vpt_tlb.sv
// Scoreboard bench: driver tasks queue expectations, a monitor checks them.
module sim_vpt_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_hi = '0, wr_mask = '0, wr_lo0 = '0, wr_lo1 = '0;
    logic [31:0] tr_va = '0;
    logic        tr_write = 1'b0;
    logic [7:0]  tr_asid = '0;
    logic [31:0] tr_pa;
    logic [1:0]  tr_status;
    logic [31:0] pr_hi = '0;
    logic [31:0] pr_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_probe;
        logic [1:0]  st;
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t q[$];

    localparam logic [1:0] S_OK = 2'd0, S_MISS = 2'd1, S_INV = 2'd2, S_MOD = 2'd3;

    always #10 clk = ~clk;

    vpt_tlb u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_hi(wr_hi), .wr_mask(wr_mask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .tr_va(tr_va), .tr_write(tr_write), .tr_asid(tr_asid),
        .tr_pa(tr_pa), .tr_status(tr_status), .pr_hi(pr_hi), .pr_index(pr_index)
    );

    function automatic logic [31:0] lo(input logic [31:0] b, input bit d, input bit v, input bit g);
        return {b[31:12], 9'd0, d, v, g};
    endfunction

    task automatic push_tr(input logic [1:0] st, input logic [31:0] pa, input string rq);
        exp_t e;
        e.is_probe = 1'b0; e.st = st; e.val = pa; e.req = rq;
        q.push_back(e);
    endtask

    task automatic tr(input logic [31:0] va, input bit w, input logic [7:0] id,
                      input logic [1:0] st, input logic [31:0] pa, input string rq);
        @(negedge clk);
        tr_va = va; tr_write = w; tr_asid = id;
        push_tr(st, pa, rq);
    endtask

    task automatic pr(input logic [31:0] hi, input logic [31:0] idx, input string rq);
        exp_t e;
        @(negedge clk);
        pr_hi = hi;
        e.is_probe = 1'b1; e.st = 2'd0; e.val = idx; e.req = rq;
        q.push_back(e);
    endtask

    task automatic fill(input logic [3:0] i, input logic [31:0] hi, input logic [31:0] m,
                        input logic [31:0] l0, input logic [31:0] l1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_hi = hi; wr_mask = m; wr_lo0 = l0; wr_lo1 = l1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: pop one expectation per cycle, mid-way to the next edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (e.is_probe) begin
                    if (pr_index !== e.val) begin
                        errors++;
                        $display("FAIL %s probe index actual=%h expected=%h", e.req, pr_index, e.val);
                    end
                end else if (tr_status !== e.st || tr_pa !== e.val) begin
                    errors++;
                    $display("FAIL %s translate actual st=%0d pa=%h expected st=%0d pa=%h",
                             e.req, tr_status, tr_pa, e.st, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: after reset entry 0 is page 0 / id 0 but invalid; elsewhere miss
        tr(32'h0000_0040, 1'b0, 8'h00, S_INV, 32'h0, "R10");
        tr(32'h4000_0000, 1'b0, 8'h05, S_MISS, 32'h0, "R10");
        pr(32'h4000_0005, 32'h8000_0000, "R9");

        // 4 KB pair at index 1, id 3: even dirty, odd clean
        fill(4'd1, 32'h0040_0003, 32'h0,
             lo(32'h1111_1000, 1'b1, 1'b1, 1'b0), lo(32'h2222_2000, 1'b0, 1'b1, 1'b0));
        tr(32'h0040_0123, 1'b0, 8'h03, S_OK, 32'h1111_1123, "R3");
        tr(32'h0040_1456, 1'b0, 8'h03, S_OK, 32'h2222_2456, "R4");
        tr(32'h0040_1456, 1'b1, 8'h03, S_MOD, 32'h0, "R6");
        tr(32'h0040_0010, 1'b1, 8'h03, S_OK, 32'h1111_1010, "R6");
        tr(32'h0040_0123, 1'b0, 8'h04, S_MISS, 32'h0, "R3");
        tr(32'h0040_2000, 1'b0, 8'h03, S_MISS, 32'h0, "R8");

        // 64 KB global pair at index 2 with junk mask bits outside 28:13
        fill(4'd2, 32'h1234_0007, 32'hE001_F001,
             lo(32'h3000_0000, 1'b1, 1'b1, 1'b1), lo(32'h4000_0000, 1'b1, 1'b0, 1'b1));
        tr(32'h1234_ABCD, 1'b0, 8'h55, S_OK, 32'h3000_ABCD, "R7");
        tr(32'h1235_ABCD, 1'b0, 8'h55, S_INV, 32'h0, "R5");
        tr(32'h9234_ABCD, 1'b0, 8'h55, S_MISS, 32'h0, "R2");

        // Global only when both low words carry it
        fill(4'd3, 32'h5000_0009, 32'h0,
             lo(32'h6000_0000, 1'b1, 1'b1, 1'b1), lo(32'h6000_1000, 1'b1, 1'b1, 1'b0));
        tr(32'h5000_0044, 1'b0, 8'h09, S_OK, 32'h6000_0044, "R1");
        tr(32'h5000_0044, 1'b0, 8'h08, S_MISS, 32'h0, "R1");

        // Duplicate of index 1 at index 5: lowest index wins
        fill(4'd5, 32'h0040_0003, 32'h0,
             lo(32'h7777_7000, 1'b1, 1'b1, 1'b0), lo(32'h7777_8000, 1'b1, 1'b1, 1'b0));
        tr(32'h0040_0123, 1'b0, 8'h03, S_OK, 32'h1111_1123, "R8");
        pr(32'h0040_0003, 32'h0000_0001, "R9");
        pr(32'h1234_8055, 32'h0000_0002, "R9");

        // Fill and translate in the same cycle: old contents answer first
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd1; wr_hi = 32'h0080_0003; wr_mask = 32'h0;
        wr_lo0 = lo(32'h0AAA_A000, 1'b1, 1'b1, 1'b0);
        wr_lo1 = lo(32'h0BBB_B000, 1'b1, 1'b1, 1'b0);
        tr_va = 32'h0080_0020; tr_write = 1'b0; tr_asid = 8'h03;
        push_tr(S_MISS, 32'h0, "R1");
        @(negedge clk);
        wr_en = 1'b0;
        push_tr(S_OK, 32'h0AAA_A020, "R1");
        tr(32'h0040_0123, 1'b0, 8'h03, S_OK, 32'h7777_7123, "R8");

        // Reset mid-run clears all entries
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        tr(32'h0080_0020, 1'b0, 8'h03, S_MISS, 32'h0, "R10");
        tr(32'h0000_0040, 1'b0, 8'h00, S_INV, 32'h0, "R10");

        @(negedge clk);
        #8;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule